// File: doc/BRIEF.md
# Multi-Queue Shared FIFO Controller

One buffer memory holds a fixed number of equal-sized FIFO queues. A single write port and a single read port serve all of them. Each port has its own 8-bit queue address. The write address picks the queue that takes the next word, and the read address picks the queue that supplies the next word. The two ports choose their queues independently, and both may point at the same queue in the same cycle. Each queue keeps its own read and write pointers in a small register file. The flags always describe the queues that the ports currently have selected.

Two settings are captured while reset is held. The first is the number of active queues; a value of zero gives the default layout, in which every queue is active. The second is the read-side mode. In standard mode a read enable loads the head word into an output register. In first-word-fall-through mode the head word of the selected queue is already present on the output before any read enable, and a read enable only removes it.

Top module: `mq_fifo_top`

## Requirements
- R1: A word accepted on the write port is stored in the queue chosen by the write-side selection. Reads from a queue return that queue's words in the order they were written, with no mixing between queues.
- R2: A queue address is sampled on each rising edge and becomes the port's selection after that edge. A transfer at a given edge uses the selection made at the previous edge, and the flags after an edge describe the newly sampled queue.
- R3: `full` is 1 when the write-selected queue holds QDEPTH words. A write while `full` is 1 is dropped, and no pointer or stored word changes.
- R4: `empty` is 1 when the read-selected queue holds no words. A read while `empty` is 1 is dropped, no pointer changes, and in standard mode `rdData` keeps its value.
- R5: `almostFull` is 1 when the write-selected queue has AF_GAP or fewer free slots. `almostEmpty` is 1 when the read-selected queue holds AE_GAP or fewer words.
- R6: Each port can complete one transfer on every clock. A simultaneous read and write on the same queue both take effect when the queue is neither full nor empty.
- R7: In standard mode (`cfgFwft`=0 during reset), an accepted read places the head word on `rdData` after that edge. `rdData` then holds that value until the next accepted read.
- R8: In first-word-fall-through mode (`cfgFwft`=1 during reset), `rdData` shows the head word of the read-selected queue whenever `empty` is 0, with no read enable needed.
- R9: `cfgQueueCount` is captured while `rst_n` is 0. A value of 0, or any value above NUM_Q, activates all NUM_Q queues. For an address at or above the active count, `full`, `almostFull`, `empty` and `almostEmpty` are all 1, and writes and reads on that address are dropped.
- R10: After reset every queue is empty, both selections are queue 0, and `rdData` is 0 in standard mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; configuration is captured while it is low |
| cfgQueueCount | input | QADDR_W | Number of active queues (0 = all) |
| cfgFwft | input | 1 | 1 selects first-word-fall-through read mode, 0 selects standard mode |
| wrQAddr | input | QADDR_W | Write-side queue address |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Write data |
| rdQAddr | input | QADDR_W | Read-side queue address |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Read data |
| full | output | 1 | Write-selected queue is full or inactive |
| almostFull | output | 1 | Write-selected queue has AF_GAP or fewer free slots |
| empty | output | 1 | Read-selected queue is empty or inactive |
| almostEmpty | output | 1 | Read-selected queue holds AE_GAP or fewer words |

## Verification
The assertions check on every cycle the following points:
- the selected queue's occupancy never exceeds its depth;
- a blocked write leaves all write pointers unchanged, and a blocked read leaves all read pointers unchanged;
- each almost flag is set whenever its hard flag is set;
- one queue selected on both ports is never reported full and empty together;
- each accepted write lands at its memory address;
- in standard mode `rdData` holds its value between accepted reads.

Only the bench's scenarios can show whether each queue returns its own words in order. The same holds for the one-edge delay of a queue switch and the effect of the captured queue count and read mode. The bench shows these by comparing against a model of each queue under random switching on both ports.

// File: rtl/mq_pkg.sv
package mq_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic memWrite;   // store wrData at the write address this edge
    logic headLoad;   // standard mode: capture the head word into the output register
    logic fwft;       // read mode captured at reset
  } mqStrobe_t;

endpackage

// File: rtl/mq_ctrl.sv
module mq_ctrl
  import mq_pkg::*;
#(
  parameter int NUM_Q   = 8,
  parameter int QDEPTH  = 8,
  parameter int QADDR_W = 8,
  parameter int AF_GAP  = 2,
  parameter int AE_GAP  = 2,
  localparam int QIDX_W  = $clog2(NUM_Q),
  localparam int DEPTH_W = $clog2(QDEPTH),
  localparam int MEM_AW  = QIDX_W + DEPTH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [QADDR_W-1:0] cfgQueueCount,
  input  logic               cfgFwft,
  input  logic [QADDR_W-1:0] wrQAddr,
  input  logic               wrEn,
  input  logic [QADDR_W-1:0] rdQAddr,
  input  logic               rdEn,
  output mqStrobe_t          strobe,
  output logic [MEM_AW-1:0]  memWrAddr,
  output logic [MEM_AW-1:0]  memRdAddr,
  output logic               full,
  output logic               almostFull,
  output logic               empty,
  output logic               almostEmpty
);

  localparam int PW = DEPTH_W + 1;   // pointer width with wrap bit

  logic [QADDR_W:0]               activeQ;
  logic                           fwftReg;
  logic [QADDR_W-1:0]             wrSel, rdSel;
  logic [NUM_Q-1:0][PW-1:0]       wrPtr, rdPtr;
  logic [QIDX_W-1:0]              wrIdx, rdIdx;
  logic                           wrOk, rdOk;
  logic [PW-1:0]                  wrCount, wrFree, rdCount;
  logic                           doWrite, doRead;
  logic [NUM_Q-1:0]               wrHit, rdHit;

  assign wrIdx = wrSel[QIDX_W-1:0];
  assign rdIdx = rdSel[QIDX_W-1:0];
  assign wrOk  = ({1'b0, wrSel} < activeQ);
  assign rdOk  = ({1'b0, rdSel} < activeQ);

  assign wrCount = wrPtr[wrIdx] - rdPtr[wrIdx];
  assign wrFree  = PW'(QDEPTH) - wrCount;
  assign rdCount = wrPtr[rdIdx] - rdPtr[rdIdx];

  assign full        = !wrOk || (wrCount == PW'(QDEPTH));
  assign almostFull  = !wrOk || (wrFree <= PW'(AF_GAP));
  assign empty       = !rdOk || (rdCount == '0);
  assign almostEmpty = !rdOk || (rdCount <= PW'(AE_GAP));

  assign doWrite = wrEn && !full;
  assign doRead  = rdEn && !empty;

  // Per-queue advance decode
  for (genvar q = 0; q < NUM_Q; q++) begin : gHit
    assign wrHit[q] = doWrite && (wrIdx == QIDX_W'(q));
    assign rdHit[q] = doRead  && (rdIdx == QIDX_W'(q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (cfgQueueCount == '0 || cfgQueueCount > QADDR_W'(NUM_Q))
        activeQ <= (QADDR_W+1)'(NUM_Q);
      else
        activeQ <= {1'b0, cfgQueueCount};
      fwftReg <= cfgFwft;
      wrSel   <= '0;
      rdSel   <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
    end else begin
      wrSel <= wrQAddr;
      rdSel <= rdQAddr;
      for (int q = 0; q < NUM_Q; q++) begin
        if (wrHit[q]) wrPtr[q] <= wrPtr[q] + 1'b1;
        if (rdHit[q]) rdPtr[q] <= rdPtr[q] + 1'b1;
      end
    end
  end

  assign memWrAddr       = {wrIdx, wrPtr[wrIdx][DEPTH_W-1:0]};
  assign memRdAddr       = {rdIdx, rdPtr[rdIdx][DEPTH_W-1:0]};
  assign strobe.memWrite = doWrite;
  assign strobe.headLoad = doRead && !fwftReg;
  assign strobe.fwft     = fwftReg;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wrCount <= PW'(QDEPTH));                                            // R3
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && full) |=> (wrPtr == $past(wrPtr)));                        // R3
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && empty) |=> (rdPtr == $past(rdPtr)));                       // R4
  AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> almostFull);                                               // R5
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> almostEmpty);                                             // R5
  AST_SAME_QUEUE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrSel == rdSel && wrOk) |-> !(full && empty));                     // R6

endmodule

// File: rtl/mq_datapath.sv
module mq_datapath
  import mq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 6,
  localparam int MEM_DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mqStrobe_t         strobe,
  input  logic [MEM_AW-1:0] wrAddr,
  input  logic [MEM_AW-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [DATA_W-1:0] headWord;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk) begin
    if (strobe.memWrite) mem[wrAddr] <= wrData;
  end

  assign headWord = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (!rst_n)               rdDataQ <= '0;
    else if (strobe.headLoad) rdDataQ <= headWord;
  end

  assign rdData = strobe.fwft ? headWord : rdDataQ;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.memWrite |=> (mem[$past(wrAddr)] == $past(wrData)));          // R1
  AST_STD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.fwft && !strobe.headLoad) |=> $stable(rdData));             // R7

endmodule

// File: rtl/mq_fifo_top.sv
module mq_fifo_top
  import mq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_Q   = 8,
  parameter int QDEPTH  = 8,
  parameter int QADDR_W = 8,
  parameter int AF_GAP  = 2,
  parameter int AE_GAP  = 2,
  localparam int MEM_AW = $clog2(NUM_Q) + $clog2(QDEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [QADDR_W-1:0] cfgQueueCount,
  input  logic               cfgFwft,
  input  logic [QADDR_W-1:0] wrQAddr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [QADDR_W-1:0] rdQAddr,
  input  logic               rdEn,
  output logic [DATA_W-1:0]  rdData,
  output logic               full,
  output logic               almostFull,
  output logic               empty,
  output logic               almostEmpty
);

  mqStrobe_t         strobe;
  logic [MEM_AW-1:0] memWrAddr, memRdAddr;

  mq_ctrl #(
    .NUM_Q(NUM_Q), .QDEPTH(QDEPTH), .QADDR_W(QADDR_W),
    .AF_GAP(AF_GAP), .AE_GAP(AE_GAP)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .cfgQueueCount(cfgQueueCount), .cfgFwft(cfgFwft),
    .wrQAddr(wrQAddr), .wrEn(wrEn),
    .rdQAddr(rdQAddr), .rdEn(rdEn),
    .strobe(strobe), .memWrAddr(memWrAddr), .memRdAddr(memRdAddr),
    .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty)
  );

  mq_datapath #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrAddr(memWrAddr), .rdAddr(memRdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/tb_mq_fifo_top.sv
module tb_mq_fifo_top;

  localparam int DW = 16;
  localparam int NQ = 8;
  localparam int D  = 8;
  localparam int AW = 8;
  localparam int AFG = 2;
  localparam int AEG = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] cfgQueueCount = '0;
  logic cfgFwft = 0;
  logic [AW-1:0] wrQAddr = '0, rdQAddr = '0;
  logic wrEn = 0, rdEn = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic full, almostFull, empty, almostEmpty;

  always #10 clk = ~clk;   // 50 MHz

  mq_fifo_top #(.DATA_W(DW), .NUM_Q(NQ), .QDEPTH(D), .QADDR_W(AW),
                .AF_GAP(AFG), .AE_GAP(AEG)) dut (
    .clk(clk), .rst_n(rst_n), .cfgQueueCount(cfgQueueCount), .cfgFwft(cfgFwft),
    .wrQAddr(wrQAddr), .wrEn(wrEn), .wrData(wrData),
    .rdQAddr(rdQAddr), .rdEn(rdEn), .rdData(rdData),
    .full(full), .almostFull(almostFull), .empty(empty), .almostEmpty(almostEmpty));

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // Reference model
  int mHead [NQ];
  int mCnt  [NQ];
  logic [DW-1:0] mData [NQ][D];
  logic [DW-1:0] mLast;
  int mW, mR, active;
  bit mFwft;

  function automatic bit mFull(int q);
    return (q >= active) || (mCnt[q] == D);
  endfunction
  function automatic bit mAF(int q);
    return (q >= active) || ((D - mCnt[q]) <= AFG);
  endfunction
  function automatic bit mEmpty(int q);
    return (q >= active) || (mCnt[q] == 0);
  endfunction
  function automatic bit mAE(int q);
    return (q >= active) || (mCnt[q] <= AEG);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(string tag);
    chk({tag, " R3 R9 full"},        32'(full),        32'(mFull(mW)));
    chk({tag, " R5 R9 almostFull"},  32'(almostFull),  32'(mAF(mW)));
    chk({tag, " R4 R9 empty"},       32'(empty),       32'(mEmpty(mR)));
    chk({tag, " R5 R9 almostEmpty"}, 32'(almostEmpty), 32'(mAE(mR)));
    if (mFwft) begin
      if (!mEmpty(mR))
        chk({tag, " R1 R2 R8 head word"}, 32'(rdData), 32'(mData[mR][mHead[mR]]));
    end else begin
      chk({tag, " R1 R2 R7 R4 read data"}, 32'(rdData), 32'(mLast));
    end
  endtask

  task automatic doReset(int qcount, bit fw);
    @(negedge clk);
    rst_n = 0; wrEn = 0; rdEn = 0; wrQAddr = '0; rdQAddr = '0;
    cfgQueueCount = AW'(qcount); cfgFwft = fw;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int q = 0; q < NQ; q++) begin mHead[q] = 0; mCnt[q] = 0; end
    mLast = '0; mW = 0; mR = 0; mFwft = fw;
    active = (qcount == 0 || qcount > NQ) ? NQ : qcount;
    checkOutputs("R10 reset");
  endtask

  // Drive one cycle at a negedge, advance the model, then check after the edge
  task automatic cycle(bit we, bit re, int wa, int ra, logic [DW-1:0] wd, string tag);
    bit doW, doR;
    int pIdx;
    wrEn = we; rdEn = re; wrQAddr = AW'(wa); rdQAddr = AW'(ra); wrData = wd;
    doW = we && !mFull(mW);
    doR = re && !mEmpty(mR);
    pIdx = 0;
    if (doW) pIdx = (mHead[mW] + mCnt[mW]) % D;
    if (doR) begin
      if (!mFwft) mLast = mData[mR][mHead[mR]];
      mHead[mR] = (mHead[mR] + 1) % D;
      mCnt[mR]--;
    end
    if (doW) begin
      mData[mW][pIdx] = wd;
      mCnt[mW]++;
    end
    mW = wa; mR = ra;
    @(posedge clk);
    @(negedge clk);
    checkOutputs(tag);
  endtask

  task automatic randomPhases();
    int hi [4]  = '{2, 9, 2, 7};
    int wp [4]  = '{90, 50, 20, 70};
    int rp [4]  = '{20, 50, 90, 70};
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 450; i++) begin
        cycle($urandom_range(99) < wp[p], $urandom_range(99) < rp[p],
              $urandom_range(hi[p]), $urandom_range(hi[p]),
              DW'($urandom), "random");
      end
    end
  endtask

  task automatic directed();
    // Fill queue 3 to full with extra writes (R3), then same-queue streaming (R6)
    cycle(0, 0, 3, 3, '0, "R2 select");
    for (int i = 0; i < D + 3; i++) cycle(1, 0, 3, 3, DW'(16'h3000 + i), "R3 fill");
    for (int i = 0; i < 12; i++) cycle(1, 1, 3, 3, DW'(16'h3100 + i), "R6 full stream");
    for (int i = 0; i < 4; i++) cycle(0, 1, 3, 3, '0, "R4 drain");
    for (int i = 0; i < 12; i++) cycle(1, 1, 3, 3, DW'(16'h3200 + i), "R6 stream");
    // Switch on the same edge as a write: word lands in the previous queue
    cycle(1, 0, 5, 3, 16'hAAAA, "R2 switch edge");
    cycle(1, 0, 5, 5, 16'hBBBB, "R2 new queue");
    for (int i = 0; i < D + 3; i++) cycle(0, 1, 5, 3, '0, "R4 empty read");
    // Out-of-range queue addresses
    cycle(1, 1, 9, 9, 16'hDEAD, "R9 range");
    cycle(1, 1, 9, 9, 16'hBEEF, "R9 range");
  endtask

  initial begin
    void'($urandom(32'd20240917));
    doReset(0, 0);          // default layout, standard mode
    directed();
    randomPhases();
    doReset(6, 1);          // six active queues, fall-through mode
    directed();
    randomPhases();
    doReset(200, 0);        // oversized count clamps to all queues
    directed();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule